// File: doc/BRIEF.md
# Converter fault supervisor

This block watches four digitized fault flags of a switching regulator and decides when the power switch must be held off. The four flags report primary-side overcurrent, die overtemperature, output undervoltage and output overvoltage. The undervoltage and overvoltage flags come from two separate comparators, each comparing against the reference. The overcurrent flag reaches the gate-kill output through logic alone, with no register in the path. The other three flags first pass a synchronizer and then a hold-time filter. Only after that do they latch a fault and shut the converter down.

Every accepted fault sets a sticky bit in the status output. A bit clears only when the clear command arrives while its own fault is inactive. While any bit is set, the converter-disable output stays high, and the converter runs again only once all bits are cleared and enable is high. The interrupt output is a level signal: the OR over the status bits, each gated by an external per-fault mask. It reaches the diagnostic logic that handles overtemperature and the other faults.

Top module: `fault_supervisor`

## Requirements
- R1: `gate_kill` goes high in the same cycle that `oc_flag` is high, with no clock edge in between.
- R2: A high `oc_flag` sets status bit 0 at the next rising clock edge. `gate_kill` then stays high after `oc_flag` falls, until that bit is cleared.
- R3: Status bit 1 belongs to `ot_flag`, bit 2 to `uv_flag` and bit 3 to `ov_flag`. A flag that is high for at least HOLD_CYC consecutive cycles (default 4) sets its bit, which appears HOLD_CYC+3 rising edges after the flag rises. A shorter pulse leaves the bit clear.
- R4: A status bit clears on the edge that samples `clr_fault` high, but only while that fault's qualified flag is inactive. For bit 0 this means `oc_flag` is low; for the other bits it means the filter output is low. If a bit is set and cleared in the same cycle, the set wins.
- R5: `conv_off` is high whenever any status bit is set or `enable` is low.
- R6: `gate_kill` is high whenever `conv_off` is high.
- R7: `irq` equals the OR over i of `fault_status[i] & irq_mask[i]`, and is a level, not a pulse.
- R8: After reset, `fault_status` is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Converter run request |
| clr_fault | input | 1 | Clear command for inactive sticky faults |
| oc_flag | input | 1 | Primary overcurrent comparator |
| ot_flag | input | 1 | Overtemperature comparator |
| uv_flag | input | 1 | Output undervoltage comparator |
| ov_flag | input | 1 | Output overvoltage comparator |
| irq_mask | input | 4 | Per-fault interrupt enable, same bit order as status |
| gate_kill | output | 1 | Forces the power switch off |
| conv_off | output | 1 | Converter disable |
| fault_status | output | 4 | Sticky fault bits |
| irq | output | 1 | Diagnostic interrupt level |

## Verification
Two functions can act on one status bit in the same cycle: setting it from a live fault and clearing it with `clr_fault`. The bench provokes this in two ways. It raises `oc_flag` on the very cycle that `clr_fault` is high. It also issues a clear while a filtered fault is still held, and again while the filter is still draining after the flag has fallen. In each case the bench expects the bit to stay set. A clear sent afterwards, once the filter has emptied, must then remove the bit.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
    localparam int NFLT = 4;

    typedef enum logic [1:0] {
        FLT_OC = 2'd0,
        FLT_OT = 2'd1,
        FLT_UV = 2'd2,
        FLT_OV = 2'd3
    } flt_idx_e;

    typedef struct packed {
        logic [NFLT-1:0] sts;
    } latch_state_t;
endpackage

// File: rtl/fsup_sync.sv
module fsup_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fsup_deglitch.sv
module fsup_deglitch #(
    parameter int HOLD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (!d_i)                cnt_d = '0;
        else if (cnt_q != HOLD_C) cnt_d = cnt_q + CW'(1);
        else                     cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign q_o = (cnt_q == HOLD_C);

    // R3
    low_input_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !d_i |=> !q_o);
endmodule

// File: rtl/fsup_latch.sv
module fsup_latch
    import fsup_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NFLT-1:0] act_i,
    input  logic            clr_i,
    output logic [NFLT-1:0] sts_o
);
    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sts = (st_q.sts & ~({NFLT{clr_i}} & ~act_i)) | act_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sts_o = st_q.sts;

    for (genvar k = 0; k < NFLT; k++) begin : g_chk
        // R4
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            act_i[k] |=> sts_o[k]);
        // R4
        clear_inactive_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_i && !act_i[k]) |=> !sts_o[k]);
        // R4
        hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (sts_o[k] && !clr_i) |=> sts_o[k]);
    end
endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
    import fsup_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYC    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            clr_fault,
    input  logic            oc_flag,
    input  logic            ot_flag,
    input  logic            uv_flag,
    input  logic            ov_flag,
    input  logic [NFLT-1:0] irq_mask,
    output logic            gate_kill,
    output logic            conv_off,
    output logic [NFLT-1:0] fault_status,
    output logic            irq
);
    logic [NFLT-1:0] raw_flags;
    logic [NFLT-1:0] sync_flags;
    logic [NFLT-1:0] qual_flags;

    assign raw_flags = {ov_flag, uv_flag, ot_flag, oc_flag};

    // overcurrent bypasses synchronizer and filter
    assign sync_flags[FLT_OC] = raw_flags[FLT_OC];
    assign qual_flags[FLT_OC] = raw_flags[FLT_OC];

    for (genvar i = 1; i < NFLT; i++) begin : g_filt
        fsup_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (raw_flags[i]),
            .q_o  (sync_flags[i])
        );
        fsup_deglitch #(.HOLD(HOLD_CYC)) u_dg (
            .clk  (clk),
            .rst_n(rst_n),
            .d_i  (sync_flags[i]),
            .q_o  (qual_flags[i])
        );
    end

    fsup_latch u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .act_i(qual_flags),
        .clr_i(clr_fault),
        .sts_o(fault_status)
    );

    assign conv_off  = (|fault_status) | ~enable;
    assign gate_kill = oc_flag | conv_off;
    assign irq       = |(fault_status & irq_mask);

    // R2
    oc_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oc_flag |=> fault_status[FLT_OC]);
    // R7
    irq_needs_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (fault_status != '0));
    // R6
    status_kills_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_status != '0) |-> gate_kill);
endmodule

// File: tb/fault_supervisor_bench.sv
module fault_supervisor_bench;
    localparam int HOLD = 4;

    logic       clk = 1'b0;
    logic       rst_n, enable, clr_fault;
    logic       oc_flag, ot_flag, uv_flag, ov_flag;
    logic [3:0] irq_mask;
    logic       gate_kill, conv_off, irq;
    logic [3:0] fault_status;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    fault_supervisor #(.SYNC_STAGES(2), .HOLD_CYC(HOLD)) u_fault_supervisor (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clr_fault(clr_fault),
        .oc_flag(oc_flag), .ot_flag(ot_flag), .uv_flag(uv_flag), .ov_flag(ov_flag),
        .irq_mask(irq_mask), .gate_kill(gate_kill), .conv_off(conv_off),
        .fault_status(fault_status), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic set_flag(input int f, input logic v);
        case (f)
            0: oc_flag = v;
            1: ot_flag = v;
            2: uv_flag = v;
            default: ov_flag = v;
        endcase
    endtask

    task automatic do_clear();
        clr_fault = 1'b1;
        cyc(1);
        clr_fault = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b1; clr_fault = 1'b0; irq_mask = 4'hF;
        oc_flag = 1'b0; ot_flag = 1'b0; uv_flag = 1'b0; ov_flag = 1'b0;
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        chk("R8 status", fault_status, 4'h0);
        chk("R8 irq", irq, 1'b0);
        chk("R5 conv_off idle", conv_off, 1'b0);
        chk("R6 gate idle", gate_kill, 1'b0);

        enable = 1'b0; #1;
        chk("R5 enable low", conv_off, 1'b1);
        chk("R6 enable low", gate_kill, 1'b1);
        cyc(1);
        enable = 1'b1; #1;
        chk("R5 enable high", conv_off, 1'b0);

        // overcurrent: same-cycle kill
        cyc(1);
        oc_flag = 1'b1; #1;
        chk("R1 gate same cycle", gate_kill, 1'b1);
        chk("R2 bit before edge", fault_status, 4'h0);
        cyc(1);
        chk("R2 bit after edge", fault_status, 4'h1);
        chk("R5 oc disables", conv_off, 1'b1);
        oc_flag = 1'b0; #1;
        chk("R2 gate held", gate_kill, 1'b1);
        do_clear();
        chk("R4 oc cleared", fault_status, 4'h0);
        chk("R6 gate released", gate_kill, 1'b0);

        // set and clear in the same cycle
        oc_flag = 1'b1; clr_fault = 1'b1;
        cyc(1);
        chk("R4 set beats clear", fault_status, 4'h1);
        oc_flag = 1'b0; clr_fault = 1'b0;
        do_clear();
        chk("R4 oc clean", fault_status, 4'h0);

        // latency of filtered path
        ot_flag = 1'b1;
        cyc(HOLD + 2);
        chk("R3 not yet", fault_status, 4'h0);
        cyc(1);
        chk("R3 latency", fault_status, 4'h2);
        do_clear();
        chk("R4 clear while held", fault_status, 4'h2);
        ot_flag = 1'b0;
        cyc(2);
        do_clear();
        chk("R4 clear while draining", fault_status, 4'h2);
        cyc(3);
        do_clear();
        chk("R4 clear after drain", fault_status, 4'h0);

        // pulse width sweep on each filtered fault
        for (int f = 1; f < 4; f++) begin
            for (int w = 1; w <= HOLD + 2; w++) begin
                set_flag(f, 1'b1);
                cyc(w);
                set_flag(f, 1'b0);
                cyc(10);
                chk($sformatf("R3 f%0d w%0d", f, w), fault_status,
                    (w >= HOLD) ? (32'd1 << f) : 32'd0);
                do_clear();
                chk("R4 sweep clear", fault_status, 4'h0);
            end
        end

        // mask sweep with all faults latched
        oc_flag = 1'b1; ot_flag = 1'b1; uv_flag = 1'b1; ov_flag = 1'b1;
        cyc(1);
        oc_flag = 1'b0;
        cyc(HOLD + 4);
        ot_flag = 1'b0; uv_flag = 1'b0; ov_flag = 1'b0;
        chk("R3 all set", fault_status, 4'hF);
        for (int m = 0; m < 16; m++) begin
            irq_mask = 4'(m); #1;
            chk($sformatf("R7 all m%0d", m), irq, (m != 0));
        end
        cyc(6);
        do_clear();
        chk("R4 all cleared", fault_status, 4'h0);

        // only undervoltage latched
        uv_flag = 1'b1;
        cyc(HOLD + 4);
        uv_flag = 1'b0;
        for (int m = 0; m < 16; m++) begin
            irq_mask = 4'(m); #1;
            chk($sformatf("R7 uv m%0d", m), irq, m[2]);
        end
        cyc(2);
        chk("R7 level held", irq, 1'b1);
        cyc(4);
        do_clear();
        #1;
        chk("R7 drops after clear", irq, 1'b0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule